// File: doc/BRIEF.md
# Oscillator Tuning Search Controller

This block steers a two-stage delay-line oscillator towards a target frequency. Each reference period, an external time digitizer reports how many oscillator pulses it counted, plus a flag saying whether the oscillator leads or lags. From these the controller picks one tap in a coarse delay line and one tap in a fine delay line. It drives each pick as a one-hot select word. It also drives a thermometer word of power-gating enables, which switches off every delay cell past the chosen tap.

The search is adaptive, not a fixed halving. The first measurement chooses the starting coarse tap straight from the measured count. Every later measurement moves the active tap by a step taken from that cycle's count error. The lead/lag flag decides the direction of the move. The coarse line is tuned first. Control passes to the fine line when the lead/lag flag reverses or the error becomes small. A zero error locks the loop, and so does a second lead/lag reversal in a row during fine tuning. Once locked, the selections stay frozen until reset.

Top module: `osc_tune_ctrl`

## Requirements
- R1: While reset is low and after it is released, both tap indices are 0 and `locked` is low. So `coarse_sel` = 1, `fine_sel` = 1, `coarse_pwr` = 1 and `fine_pwr` = 1.
- R2: The first valid measurement after reset sets the coarse index to min(`meas_cnt` >> 5, 11). The fine index stays 0, lock is never declared on this measurement, and the coarse tuning phase begins.
- R3: A later measurement that does none of R5 and R7 moves the active index by max(|`meas_cnt` − `target_cnt`| >> 2, 1). The index goes up when `osc_lead` = 1 and down when `osc_lead` = 0.
- R4: Index moves saturate: the coarse index stays within 0..11 and the fine index stays within 0..43.
- R5: In the coarse phase, a nonzero-error measurement moves no tap and switches to the fine phase when either of two things holds. Either its `osc_lead` differs from the previous measurement's, or its error is below 16.
- R6: In the fine phase, measurements move only the fine index and leave the coarse index unchanged.
- R7: Any measurement after the first that has zero error sets `locked` and moves no tap, whatever its `osc_lead`. In the fine phase, an `osc_lead` reversal whose previous measurement was also a reversal sets `locked` and moves no tap.
- R8: Once `locked` is high, it stays high, and the measurements that follow change no output until reset.
- R9: `coarse_sel` and `fine_sel` are each one-hot, with the set bit at the current index.
- R10: `coarse_pwr` and `fine_pwr` are high for every cell at or below the current index and low for every cell above it.
- R11: A cycle with `meas_valid` low changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| meas_cnt | input | 9 | Pulse count measured over one reference period |
| meas_valid | input | 1 | Strobe: `meas_cnt` and `osc_lead` hold a new measurement |
| osc_lead | input | 1 | 1 = oscillator leads (add delay), 0 = lags (remove delay) |
| target_cnt | input | 9 | Pulse count that corresponds to the wanted frequency |
| coarse_sel | output | 12 | One-hot coarse tap select |
| fine_sel | output | 44 | One-hot fine tap select |
| coarse_pwr | output | 12 | Coarse cell power enables (thermometer) |
| fine_pwr | output | 44 | Fine cell power enables (thermometer) |
| locked | output | 1 | Search finished; selections frozen |

## Verification
Two decisions can hit the same measurement during coarse tuning. A count equal to the target can arrive with a reversed lead/lag flag, so both the zero-error lock and the coarse-to-fine handover apply. The bench provokes this by making a coarse move downward and then reporting exactly the target count with the flag flipped. It expects the lock to win, with neither index moving. A second collision occurs in fine tuning, where a reversal would both move the fine tap and count towards lock. That case is judged by checking that the first reversal moves the tap by the computed step, and that the second reversal in a row only locks.

// File: rtl/osc_tune_pkg.sv
// Package: shared types for the oscillator tuning search controller.
// Assumes: nothing beyond IEEE 1800-2017.
package osc_tune_pkg;

    // Search phase: waiting for first count, coarse tuning, fine tuning, locked
    typedef enum logic [1:0] {
        PH_START  = 2'd0,
        PH_COARSE = 2'd1,
        PH_FINE   = 2'd2,
        PH_LOCK   = 2'd3
    } tune_phase_t;

endpackage : osc_tune_pkg

// File: rtl/osc_tune_err.sv
// Module: osc_tune_err
// Computes the absolute count error against the target, the step size taken
// from it (error shifted right, minimum one tap), and the zero and "near"
// flags used by the search.
// Assumes: meas_cnt and target_cnt are unsigned counts of the same width.
module osc_tune_err #(
    parameter int CNT_W = 9,
    parameter int SHIFT = 2,
    parameter int NEAR  = 16
) (
    input  logic [CNT_W-1:0] meas_cnt,
    input  logic [CNT_W-1:0] target_cnt,
    output logic [CNT_W-1:0] step,
    output logic             err_zero,
    output logic             err_near
);

    localparam logic [CNT_W-1:0] NEAR_V = CNT_W'(NEAR);
    localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

    logic [CNT_W-1:0] abs_err;
    logic [CNT_W-1:0] shifted;

    // Absolute difference between measured and target counts
    always_comb begin
        if (meas_cnt >= target_cnt) abs_err = meas_cnt - target_cnt;
        else                        abs_err = target_cnt - meas_cnt;
    end

    // Step size with a floor of one tap
    always_comb begin
        shifted = abs_err >> SHIFT;
        step    = (shifted == '0) ? ONE_V : shifted;
    end

    // Classification flags
    always_comb begin
        err_zero = (abs_err == '0);
        err_near = (abs_err < NEAR_V);
    end

endmodule : osc_tune_err

// File: rtl/osc_tune_sat.sv
// Module: osc_tune_sat
// Moves a tap index up or down by a step and saturates at 0 and N-1.
// Assumes: idx is already within 0..N-1.
module osc_tune_sat #(
    parameter int N      = 12,
    parameter int IDX_W  = 4,
    parameter int STEP_W = 9
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [STEP_W-1:0] step,
    input  logic              up,
    output logic [IDX_W-1:0]  idx_next
);

    localparam int EW = ((IDX_W > STEP_W) ? IDX_W : STEP_W) + 1;
    localparam logic [EW-1:0] MAX_V = EW'(N - 1);

    logic [EW-1:0] idx_e;
    logic [EW-1:0] step_e;
    logic [EW-1:0] sum_e;

    // Widen operands so the sum cannot wrap
    always_comb begin
        idx_e  = EW'(idx);
        step_e = EW'(step);
        sum_e  = idx_e + step_e;
    end

    // Saturating move in the requested direction
    always_comb begin
        if (up) begin
            idx_next = (sum_e > MAX_V) ? MAX_V[IDX_W-1:0] : sum_e[IDX_W-1:0];
        end else if (step_e > idx_e) begin
            idx_next = '0;
        end else begin
            idx_next = idx - step[IDX_W-1:0];
        end
    end

endmodule : osc_tune_sat

// File: rtl/osc_tune_decode.sv
// Module: osc_tune_decode
// Turns a tap index into a one-hot select word and a thermometer of
// power-gating enables (cells 0..idx powered).
// Assumes: idx within 0..N-1.
module osc_tune_decode #(
    parameter int N     = 12,
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] idx,
    output logic [N-1:0]     sel,
    output logic [N-1:0]     pwr
);

    // One comparator pair per delay cell
    for (genvar i = 0; i < N; i++) begin : g_cell
        assign sel[i] = (idx == IDX_W'(i));
        assign pwr[i] = (IDX_W'(i) <= idx);
    end

endmodule : osc_tune_decode

// File: rtl/osc_tune_fsm.sv
// Module: osc_tune_fsm
// Search sequencer: sets the starting coarse tap from the first count,
// walks the coarse then the fine index by the supplied step, detects the
// handover and lock conditions, and freezes after lock.
// Assumes: step/err flags are combinational from the current measurement.
module osc_tune_fsm
    import osc_tune_pkg::*;
#(
    parameter int CNT_W    = 9,
    parameter int COARSE_N = 12,
    parameter int FINE_N   = 44,
    parameter int CIDX_W   = 4,
    parameter int FIDX_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              meas_valid,
    input  logic              osc_lead,
    input  logic [CNT_W-1:0]  meas_cnt,
    input  logic [CNT_W-1:0]  step,
    input  logic              err_zero,
    input  logic              err_near,
    output logic [CIDX_W-1:0] cidx,
    output logic [FIDX_W-1:0] fidx,
    output logic              locked
);

    localparam int START_SH = CNT_W - CIDX_W;
    localparam logic [CNT_W-1:0]  C_MAX_W = CNT_W'(COARSE_N - 1);
    localparam logic [CIDX_W-1:0] C_MAX_I = CIDX_W'(COARSE_N - 1);

    tune_phase_t       phase;
    logic              prev_lead;
    logic              flip_once;
    logic              flip;
    logic [CNT_W-1:0]  start_raw;
    logic [CIDX_W-1:0] start_idx;
    logic [CIDX_W-1:0] c_moved;
    logic [FIDX_W-1:0] f_moved;

    // Candidate moves for both lines
    osc_tune_sat #(.N(COARSE_N), .IDX_W(CIDX_W), .STEP_W(CNT_W)) u_csat (
        .idx(cidx), .step(step), .up(osc_lead), .idx_next(c_moved)
    );
    osc_tune_sat #(.N(FINE_N), .IDX_W(FIDX_W), .STEP_W(CNT_W)) u_fsat (
        .idx(fidx), .step(step), .up(osc_lead), .idx_next(f_moved)
    );

    // Starting coarse tap from the first measured count, clipped
    always_comb begin
        start_raw = meas_cnt >> START_SH;
        start_idx = (start_raw > C_MAX_W) ? C_MAX_I : start_raw[CIDX_W-1:0];
    end

    // Lead/lag reversal against the previous measurement
    assign flip = (osc_lead != prev_lead);

    // Phase, index and reversal tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_START;
            cidx      <= '0;
            fidx      <= '0;
            prev_lead <= 1'b0;
            flip_once <= 1'b0;
        end else if (meas_valid) begin
            case (phase)
                PH_START: begin
                    cidx      <= start_idx;
                    prev_lead <= osc_lead;
                    phase     <= PH_COARSE;
                end
                PH_COARSE: begin
                    prev_lead <= osc_lead;
                    if (err_zero) begin
                        phase <= PH_LOCK;
                    end else if (flip || err_near) begin
                        phase     <= PH_FINE;
                        flip_once <= 1'b0;
                    end else begin
                        cidx <= c_moved;
                    end
                end
                PH_FINE: begin
                    prev_lead <= osc_lead;
                    if (err_zero || (flip && flip_once)) begin
                        phase <= PH_LOCK;
                    end else begin
                        fidx      <= f_moved;
                        flip_once <= flip;
                    end
                end
                default: begin
                    phase <= PH_LOCK;
                end
            endcase
        end
    end

    // Lock output
    assign locked = (phase == PH_LOCK);

endmodule : osc_tune_fsm

// File: rtl/osc_tune_ctrl.sv
// Module: osc_tune_ctrl (top)
// Oscillator tuning search controller: error/step calculation, search
// sequencer and the two tap decoders.
// Assumes: one measurement per meas_valid pulse; target_cnt held steady.
module osc_tune_ctrl #(
    parameter int CNT_W    = 9,
    parameter int COARSE_N = 12,
    parameter int FINE_N   = 44,
    parameter int SHIFT    = 2,
    parameter int NEAR     = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    meas_cnt,
    input  logic                meas_valid,
    input  logic                osc_lead,
    input  logic [CNT_W-1:0]    target_cnt,
    output logic [COARSE_N-1:0] coarse_sel,
    output logic [FINE_N-1:0]   fine_sel,
    output logic [COARSE_N-1:0] coarse_pwr,
    output logic [FINE_N-1:0]   fine_pwr,
    output logic                locked
);

    localparam int CIDX_W = $clog2(COARSE_N);
    localparam int FIDX_W = $clog2(FINE_N);

    logic [CNT_W-1:0]  step;
    logic              err_zero;
    logic              err_near;
    logic [CIDX_W-1:0] cidx;
    logic [FIDX_W-1:0] fidx;

    // Error and step from the current measurement
    osc_tune_err #(.CNT_W(CNT_W), .SHIFT(SHIFT), .NEAR(NEAR)) u_err (
        .meas_cnt(meas_cnt), .target_cnt(target_cnt),
        .step(step), .err_zero(err_zero), .err_near(err_near)
    );

    // Search sequencer
    osc_tune_fsm #(
        .CNT_W(CNT_W), .COARSE_N(COARSE_N), .FINE_N(FINE_N),
        .CIDX_W(CIDX_W), .FIDX_W(FIDX_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid),
        .osc_lead(osc_lead), .meas_cnt(meas_cnt), .step(step),
        .err_zero(err_zero), .err_near(err_near),
        .cidx(cidx), .fidx(fidx), .locked(locked)
    );

    // Coarse line decoder
    osc_tune_decode #(.N(COARSE_N), .IDX_W(CIDX_W)) u_cdec (
        .idx(cidx), .sel(coarse_sel), .pwr(coarse_pwr)
    );

    // Fine line decoder
    osc_tune_decode #(.N(FINE_N), .IDX_W(FIDX_W)) u_fdec (
        .idx(fidx), .sel(fine_sel), .pwr(fine_pwr)
    );

endmodule : osc_tune_ctrl

// File: rtl/osc_tune_ctrl_chk.sv
// Module: osc_tune_ctrl_chk
// Property checker bound to osc_tune_ctrl; observes its ports only.
module osc_tune_ctrl_chk #(
    parameter int COARSE_N = 12,
    parameter int FINE_N   = 44
) (
    input logic                clk,
    input logic                rst_n,
    input logic                meas_valid,
    input logic [COARSE_N-1:0] coarse_sel,
    input logic [FINE_N-1:0]   fine_sel,
    input logic [COARSE_N-1:0] coarse_pwr,
    input logic [FINE_N-1:0]   fine_pwr,
    input logic                locked
);

    localparam logic [COARSE_N-1:0] C_ONE = COARSE_N'(1);
    localparam logic [FINE_N-1:0]   F_ONE = FINE_N'(1);

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (coarse_sel == C_ONE && fine_sel == F_ONE && !locked)); // R1

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(coarse_sel) == 1 && $countones(fine_sel) == 1)); // R9

    AST_PWR_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
        (coarse_pwr == ((coarse_sel << 1) - C_ONE) &&
         fine_pwr == ((fine_sel << 1) - F_ONE))); // R10

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked); // R8

    AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(coarse_sel) && $stable(fine_sel))); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_valid |=> ($stable(coarse_sel) && $stable(fine_sel) && $stable(locked))); // R11

    AST_ONE_LINE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(coarse_sel) && !$stable(fine_sel))); // R6

endmodule : osc_tune_ctrl_chk

bind osc_tune_ctrl osc_tune_ctrl_chk #(.COARSE_N(COARSE_N), .FINE_N(FINE_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid),
    .coarse_sel(coarse_sel), .fine_sel(fine_sel),
    .coarse_pwr(coarse_pwr), .fine_pwr(fine_pwr), .locked(locked)
);

// File: tb/sim_osc_tune_ctrl.sv
// Scoreboard bench: the driver pushes expected tap indices per measurement,
// the monitor pops them once the design has registered that measurement.
module sim_osc_tune_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  meas_cnt = '0;
    logic        meas_valid = 1'b0;
    logic        osc_lead = 1'b0;
    logic [8:0]  target_cnt = 9'd100;
    logic [11:0] coarse_sel;
    logic [43:0] fine_sel;
    logic [11:0] coarse_pwr;
    logic [43:0] fine_pwr;
    logic        locked;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int    qc[$];
    int    qf[$];
    bit    ql[$];
    string qt[$];

    always #4 clk = ~clk;

    osc_tune_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .meas_cnt(meas_cnt), .meas_valid(meas_valid),
        .osc_lead(osc_lead), .target_cnt(target_cnt),
        .coarse_sel(coarse_sel), .fine_sel(fine_sel),
        .coarse_pwr(coarse_pwr), .fine_pwr(fine_pwr), .locked(locked)
    );

    task automatic check_outs(input int c, input int f, input bit lk, input string tag);
        logic [11:0] ecs;
        logic [43:0] efs;
        logic [11:0] ecp;
        logic [43:0] efp;
        ecs = 12'd1 << c;
        efs = 44'd1 << f;
        ecp = 12'd0;
        efp = 44'd0;
        for (int i = 0; i <= c; i++) ecp[i] = 1'b1;
        for (int i = 0; i <= f; i++) efp[i] = 1'b1;
        n_chk++;
        if (coarse_sel !== ecs || coarse_pwr !== ecp) begin
            n_fail++;
            $display("FAIL %s R9/R10 coarse sel=%h pwr=%h expected sel=%h pwr=%h",
                     tag, coarse_sel, coarse_pwr, ecs, ecp);
        end
        n_chk++;
        if (fine_sel !== efs || fine_pwr !== efp) begin
            n_fail++;
            $display("FAIL %s R9/R10 fine sel=%h pwr=%h expected sel=%h pwr=%h",
                     tag, fine_sel, fine_pwr, efs, efp);
        end
        n_chk++;
        if (locked !== lk) begin
            n_fail++;
            $display("FAIL %s locked=%b expected %b", tag, locked, lk);
        end
    endtask

    // Driver: one measurement, followed by one idle cycle
    task automatic meas(input int cnt, input bit ld, input int c, input int f,
                        input bit lk, input string tag);
        @(negedge clk);
        meas_cnt   = 9'(cnt);
        osc_lead   = ld;
        meas_valid = 1'b1;
        qc.push_back(c); qf.push_back(f); ql.push_back(lk); qt.push_back(tag);
        @(negedge clk);
        meas_valid = 1'b0;
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_outs(0, 0, 1'b0, tag);
        rst_n = 1'b1;
        @(negedge clk);
        check_outs(0, 0, 1'b0, tag);
    endtask

    // Monitor: compare once the registered measurement is visible
    initial begin
        forever begin
            @(posedge clk);
            if (meas_valid && rst_n) begin
                @(negedge clk);
                if (qc.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL scoreboard: result with no expected item");
                end else begin
                    check_outs(qc.pop_front(), qf.pop_front(), ql.pop_front(), qt.pop_front());
                end
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired: actual hung, expected completion");
        finish_run();
    end

    initial begin
        do_reset("R1 reset");
        // Scenario A: coarse walk, handover, fine walk, reversal lock
        meas(200, 1, 6, 0, 0, "R2 start from count");
        meas(140, 1, 11, 0, 0, "R4 coarse saturates high");
        meas(60, 0, 11, 0, 0, "R5 reversal hands over");
        meas(70, 0, 11, 0, 0, "R4 fine saturates low");
        meas(150, 1, 11, 12, 0, "R6 fine step up");
        meas(110, 1, 11, 14, 0, "R6 fine step no reversal");
        meas(99, 0, 11, 13, 0, "R3 minimum step one");
        meas(101, 1, 11, 13, 1, "R7 second reversal locks");
        meas(300, 0, 11, 13, 1, "R8 ignored after lock");
        repeat (4) @(negedge clk);
        check_outs(11, 13, 1'b1, "R8 still locked");
        // Scenario B: idle hold, low saturation, zero error beats reversal
        do_reset("R1 reset after lock");
        meas(40, 0, 1, 0, 0, "R2 start low");
        repeat (5) @(negedge clk);
        check_outs(1, 0, 1'b0, "R11 idle no change");
        meas(200, 0, 0, 0, 0, "R4 coarse saturates low");
        meas(100, 1, 0, 0, 1, "R7 zero error wins over reversal");
        // Scenario C: clipped start, near handover, fine move, zero lock
        do_reset("R1 reset again");
        meas(400, 1, 11, 0, 0, "R2 start clipped");
        meas(110, 1, 11, 0, 0, "R5 near error hands over");
        meas(120, 1, 11, 5, 0, "R6 fine move");
        meas(100, 1, 11, 5, 1, "R7 zero error in fine");
        // Scenario D: unsaturated coarse step
        do_reset("R1 reset D");
        meas(64, 1, 2, 0, 0, "R2 start mid");
        meas(132, 1, 10, 0, 0, "R3 coarse step eight");
        meas(84, 0, 10, 0, 0, "R5 reversal no move");
        repeat (3) @(negedge clk);
        n_chk++;
        if (qc.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", qc.size());
        end
        finish_run();
    end

endmodule : sim_osc_tune_ctrl